// File: doc/BRIEF.md
# Byte-wide CRC-32 encoder with run-time polynomial

The block turns one data byte into a 32-bit check value by modulo-2 division. The byte is extended with 32 zero bits and the 40-bit value is divided by a 33-bit generator polynomial that arrives on an input port, so software-free datapaths can switch polynomials from one byte to the next. The division is an unrolled combinational network of eight shift/conditional-XOR stages, taken most significant data bit first, and it settles within one clock period.

Two registered results appear one clock after the byte is presented. The first is the 32-bit remainder. The second is a 40-bit systematic codeword: the byte in the top eight bits, the remainder below it. Every byte is encoded on its own, with no history, no preset value, no bit reflection and no final inversion. A synchronous clear input forces both results to zero, and an asynchronous active-low reset does the same.

Top module: `byte_crc_enc`

## Requirements
- R1: While rst_ni is low, rem_o and cw_o read zero, without waiting for a clock edge.
- R2: When clr_i is high at a rising clock edge, rem_o and cw_o read zero after that edge, whatever data_i and poly_i hold.
- R3: When clr_i is low at a rising clock edge, rem_o after that edge equals the remainder of (data_i shifted left by 32) divided modulo-2 by poly_i, as sampled at that edge.
- R4: cw_o bits 39:32 hold the byte sampled at the same edge and cw_o bits 31:0 always equal rem_o.
- R5: poly_i bit 32 enables reduction; with it clear no division step fires, rem_o reads zero and cw_o reads the byte followed by 32 zero bits.
- R6: No state carries between bytes: a byte gives the same result whatever bytes came before it.
- R7: With poly_i = 0x104C11DB7: 0xD3 gives 0x1CD86D30, 0x1E gives 0x709F7B7A, 0xFF gives 0xB1F740B4, 0x0F gives 0x384FBDBD, 0xD4 gives 0x029F3D35, 0xD5 gives 0x065E2082, 0xD6 gives 0x0B1D065B, 0xD7 gives 0x0FDC1BEC.
- R8: Dividing any produced codeword modulo-2 by the same polynomial (bit 32 set) leaves zero.
- R9: Byte 0x00 gives remainder zero; byte 0x01 gives remainder equal to poly_i bits 31:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of both results, active high |
| data_i | input | 8 | Byte to encode |
| poly_i | input | 33 | Generator polynomial, bit 32 is the x^32 term |
| rem_o | output | 32 | Registered remainder |
| cw_o | output | 40 | Registered codeword, byte over remainder |

## Verification
The properties assume that data_i, poly_i and clr_i are settled before each rising edge and that a useful polynomial carries bit 32 set; the bench drives all inputs on the falling edge and uses bit 32 clear only in the one directed case that exercises that rule. The known-answer vectors use the Ethernet polynomial, while the zero-byte, one-byte and divisibility cases also run under a second polynomial so that the run-time polynomial path is not tested with one value alone.

// File: rtl/crc_enc_pkg.sv
package crc_enc_pkg;
  localparam int unsigned DATA_W_DEF = 8;
  localparam int unsigned CRC_W_DEF  = 32;
  localparam logic [CRC_W_DEF:0] POLY_ETH = 33'h1_04C1_1DB7;
endpackage

// File: rtl/crc_bit_step.sv
// One division stage: absorb one data bit, MSB first.
module crc_bit_step #(
  parameter int unsigned CRC_W = 32
) (
  input  logic [CRC_W-1:0] r_i,
  input  logic             bit_i,
  input  logic [CRC_W:0]   poly_i,
  output logic [CRC_W-1:0] r_o
);
  logic fb;
  assign fb  = (r_i[CRC_W-1] ^ bit_i) & poly_i[CRC_W];
  assign r_o = {r_i[CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & poly_i[CRC_W-1:0]);
endmodule

// File: rtl/crc_byte_net.sv
module crc_byte_net #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CRC_W  = 32
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [CRC_W:0]    poly_i,
  output logic [CRC_W-1:0]  rem_o
);
  logic [DATA_W:0][CRC_W-1:0] stage;
  assign stage[0] = '0;

  for (genvar k = 0; k < DATA_W; k++) begin : g_step
    crc_bit_step #(.CRC_W(CRC_W)) u_step (
      .r_i   (stage[k]),
      .bit_i (data_i[DATA_W-1-k]),
      .poly_i(poly_i),
      .r_o   (stage[k+1])
    );
  end

  assign rem_o = stage[DATA_W];
endmodule

// File: rtl/crc_out_reg.sv
module crc_out_reg #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CRC_W  = 32,
  localparam int unsigned CW_W  = DATA_W + CRC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CRC_W-1:0]  rem_i,
  output logic [CRC_W-1:0]  rem_o,
  output logic [CW_W-1:0]   cw_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_o <= '0;
      cw_o  <= '0;
    end else if (clr_i) begin
      rem_o <= '0;
      cw_o  <= '0;
    end else begin
      rem_o <= rem_i;
      cw_o  <= {data_i, rem_i};
    end
  end
endmodule

// File: rtl/byte_crc_enc.sv
module byte_crc_enc
  import crc_enc_pkg::*;
#(
  parameter int unsigned DATA_W = DATA_W_DEF,
  parameter int unsigned CRC_W  = CRC_W_DEF,
  localparam int unsigned POLY_W = CRC_W + 1,
  localparam int unsigned CW_W   = DATA_W + CRC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [POLY_W-1:0] poly_i,
  output logic [CRC_W-1:0]  rem_o,
  output logic [CW_W-1:0]   cw_o
);
  logic [CRC_W-1:0] rem_d;

  crc_byte_net #(.DATA_W(DATA_W), .CRC_W(CRC_W)) u_net (
    .data_i(data_i),
    .poly_i(poly_i),
    .rem_o (rem_d)
  );

  crc_out_reg #(.DATA_W(DATA_W), .CRC_W(CRC_W)) u_reg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_i),
    .data_i(data_i),
    .rem_i (rem_d),
    .rem_o (rem_o),
    .cw_o  (cw_o)
  );
endmodule

// File: rtl/byte_crc_enc_chk.sv
module byte_crc_enc_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CRC_W  = 32,
  localparam int unsigned POLY_W = CRC_W + 1,
  localparam int unsigned CW_W   = DATA_W + CRC_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clr_i,
  input logic [DATA_W-1:0] data_i,
  input logic [POLY_W-1:0] poly_i,
  input logic [CRC_W-1:0]  rem_o,
  input logic [CW_W-1:0]   cw_o
);
  // R1
  always @(negedge clk_i) begin
    if (!rst_ni) begin
      rst_zero_chk: assert (rem_o == '0 && cw_o == '0);
    end
  end

  // R2
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (rem_o == '0 && cw_o == '0));

  // R4
  cw_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw_o[CRC_W-1:0] == rem_o);

  // R4
  cw_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> cw_o[CW_W-1:CRC_W] == $past(data_i));

  // R9
  zero_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && data_i == '0) |=> rem_o == '0);

  // R9
  one_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && data_i == DATA_W'(1) && poly_i[CRC_W]) |=> rem_o == $past(poly_i[CRC_W-1:0]));

  // R5
  no_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !poly_i[CRC_W]) |=> rem_o == '0);
endmodule

bind byte_crc_enc byte_crc_enc_chk #(.DATA_W(DATA_W), .CRC_W(CRC_W)) u_chk (.*);

// File: tb/byte_crc_enc_bench.sv
module byte_crc_enc_bench;
  localparam logic [32:0] P_ETH = 33'h1_04C1_1DB7;
  localparam logic [32:0] P_ALT = 33'h1_1EDC_6F41;
  localparam int unsigned NV = 8;
  // {byte, remainder} under P_ETH (R7)
  localparam logic [39:0] VEC [NV] = '{
    40'hD3_1CD86D30, 40'h1E_709F7B7A, 40'hFF_B1F740B4, 40'h0F_384FBDBD,
    40'hD4_029F3D35, 40'hD5_065E2082, 40'hD6_0B1D065B, 40'hD7_0FDC1BEC
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clr_i = 1'b0;
  logic [7:0]  data_i = '0;
  logic [32:0] poly_i = P_ETH;
  logic [31:0] rem_o;
  logic [39:0] cw_o;
  int checks = 0;
  int fails  = 0;

  always #10 clk_i = ~clk_i;

  byte_crc_enc u_byte_crc_enc (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i),
    .data_i(data_i), .poly_i(poly_i), .rem_o(rem_o), .cw_o(cw_o)
  );

  function automatic logic [31:0] mod40(input logic [39:0] v, input logic [32:0] p);
    logic [39:0] t = v;
    for (int i = 39; i >= 32; i--) begin
      if (t[i]) t[i -: 33] = t[i -: 33] ^ p;
    end
    return t[31:0];
  endfunction

  task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(input logic [7:0] d, input logic [32:0] p, input logic c);
    data_i = d; poly_i = p; clr_i = c;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    @(negedge clk_i);
    check("R1 rem in reset", 40'(rem_o), 40'h0);
    check("R1 cw in reset", cw_o, 40'h0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][39:32], P_ETH, 1'b0);
      check("R7 R3 remainder", 40'(rem_o), 40'(VEC[i][31:0]));
      check("R4 codeword", cw_o, VEC[i]);
      check("R8 codeword divides", 40'(mod40(cw_o, P_ETH)), 40'h0);
    end

    // R6: same byte after different history
    step(8'hFF, P_ETH, 1'b0);
    step(8'h1E, P_ETH, 1'b0);
    check("R6 after FF", 40'(rem_o), 40'h709F7B7A);
    step(8'h00, P_ETH, 1'b0);
    check("R9 zero byte", cw_o, 40'h0);
    step(8'h1E, P_ETH, 1'b0);
    check("R6 after 00", 40'(rem_o), 40'h709F7B7A);

    // R3 with a second polynomial
    step(8'hA5, P_ALT, 1'b0);
    check("R3 alt poly", 40'(rem_o), 40'(mod40({8'hA5, 32'h0}, P_ALT)));
    check("R8 alt poly divides", 40'(mod40(cw_o, P_ALT)), 40'h0);
    step(8'h01, P_ALT, 1'b0);
    check("R9 one byte", 40'(rem_o), 40'h1EDC6F41);

    // R5: bit 32 clear
    step(8'h1E, {1'b0, P_ETH[31:0]}, 1'b0);
    check("R5 rem no top bit", 40'(rem_o), 40'h0);
    check("R5 cw no top bit", cw_o, 40'h1E_00000000);

    // R2: clear overrides data
    step(8'hD3, P_ETH, 1'b0);
    step(8'hFF, P_ETH, 1'b1);
    check("R2 rem cleared", 40'(rem_o), 40'h0);
    check("R2 cw cleared", cw_o, 40'h0);
    step(8'hD3, P_ETH, 1'b0);
    check("R2 after clear", cw_o, 40'hD3_1CD86D30);

    // R1: asynchronous reset between edges
    step(8'hFF, P_ETH, 1'b0);
    check("R7 before async reset", 40'(rem_o), 40'hB1F740B4);
    #3 rst_ni = 1'b0;
    #2;
    check("R1 async rem", 40'(rem_o), 40'h0);
    check("R1 async cw", cw_o, 40'h0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(8'h0F, P_ETH, 1'b0);
    check("R1 resume", cw_o, 40'h0F_384FBDBD);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule